// File: doc/BRIEF.md
# MEI Snooping Cache-Line State Controller

This block holds the coherency state and tag for each line of a small direct-mapped, write-back data cache. Each line is modified, exclusive or invalid; there is no shared state. Local loads and stores arrive on a valid/ready request port. A hit completes in the same cycle. A miss becomes one or two bus requests: a write-back of a dirty victim, then a line fill. A coherent fill always goes out as a read-with-intent-to-modify. A finished fill leaves the line exclusive, so a later store can dirty it without any bus traffic.

Snooped transactions from other masters are checked against the same tag/state array. A cacheable snoop that hits a dirty line is retried and the line is pushed to memory, then invalidated. A caching-inhibited read that hits a dirty line also pushes the data, but the line then drops to exclusive, so a non-caching reader does not evict it. Snoops on pages whose coherency attribute is clear are ignored.

The line address is split with the low `$clog2(LINES)` bits as the index and the remaining upper bits as the tag. Back-pressure rules:
- **Request port.** The requester holds `cpu_valid`, `cpu_write`, `cpu_coh` and `cpu_addr` steady until the access is accepted (`cpu_valid && cpu_ready`).
- **Bus request port.** The controller holds `bus_req_valid`, `bus_op` and `bus_addr` steady until it sees `bus_req_ready`. A bus acknowledge is one cycle of `bus_req_ready`.

Top module: `mei_line_ctrl`

## Requirements
- R1: After reset every line is invalid, and `bus_req_valid`, `snp_hit`, `snp_retry` and `cpu_ready` are low.
- R2: A miss requests a fill at the requested line address. `bus_op` is 1 (read-with-intent-to-modify) when `cpu_coh` is 1, and 0 (plain read) when `cpu_coh` is 0.
- R3: An acknowledged fill leaves the line exclusive with the new tag. The waiting access is accepted in the first cycle after the acknowledge.
- R4: A store that hits an exclusive line makes it modified. The store is accepted in the same cycle and no bus request is raised.
- R5: A coherent snoop with `snp_inh`=0 (cacheable read or write) that hits a modified line raises `snp_hit` and `snp_retry` in that cycle. The controller then requests a push (`bus_op` 2) at the snooped line address, and the line is invalid once the push is acknowledged.
- R6: A coherent snoop with `snp_inh`=0 that hits an exclusive line raises `snp_hit` without `snp_retry`. It raises no bus request, and the line becomes invalid.
- R7: A coherent snoop with `snp_inh`=1 (caching-inhibited read, single or burst) that hits a modified line is retried and pushed (`bus_op` 2). Once the push is acknowledged the line is exclusive.
- R8: A coherent snoop with `snp_inh`=1 that hits an exclusive line raises `snp_hit` without `snp_retry`. It raises no bus request and leaves state and tag unchanged.
- R9: A snoop with `snp_coh`=0 gives neither `snp_hit` nor `snp_retry` and changes no line.
- R10: While any bus request is outstanding, every coherent snoop gets `snp_retry`.
- R11: A miss whose indexed line is modified first requests a write-back (`bus_op` 3) at the victim address `{stored tag, index}`. Only after that acknowledge does it request the fill.
- R12: Once raised, `bus_req_valid` stays high with `bus_op` and `bus_addr` unchanged until `bus_req_ready` is seen.
- R13: In an idle cycle, a coherent snoop takes precedence over a pending local access, and `cpu_ready` stays low in that cycle.
- R14: A local hit is accepted in the same cycle `cpu_valid` is presented, and a load hit changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Local access request valid |
| cpu_ready | output | 1 | Local access accepted this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_coh | input | 1 | Page coherency attribute of the local access |
| cpu_addr | input | LAW | Local line address |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_coh | input | 1 | Coherency attribute of the snooped transaction |
| snp_inh | input | 1 | 1 = caching-inhibited read, 0 = cacheable read or write |
| snp_addr | input | LAW | Snooped line address |
| snp_hit | output | 1 | Snoop matched a valid line |
| snp_retry | output | 1 | Snooping master must retry |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request acknowledged |
| bus_op | output | 2 | 0 read, 1 read-with-intent-to-modify, 2 snoop push, 3 victim write-back |
| bus_addr | output | LAW | Line address of the bus request |

## Verification
Some behaviours are checked by assertions on every cycle:
- bus-request hold under back-pressure;
- retry of every coherent snoop while a request is outstanding;
- silence on non-coherent snoops;
- precedence of snoops over local accesses;
- a push following a dirty snoop hit at the snooped address;
- a fill following a victim write-back;
- no bus traffic after an accepted hit.

The resulting line states are not visible at the ports, so only the bench's sweeps show them. Every line is walked through fill, dirtying, inhibited and cacheable snoops, and victim eviction. Each later hit, miss, push or silence is compared with a model of the three-state protocol.

// File: rtl/mei_pkg.sv
package mei_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_EXC = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_READ  = 2'd0,
    BOP_RWITM = 2'd1,
    BOP_PUSH  = 2'd2,
    BOP_WBACK = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_VICT = 2'd1,
    CS_FILL = 2'd2,
    CS_PUSH = 2'd3
  } ctl_st_e;

  typedef struct packed {
    logic hit;
    logic push;
    logic inval;
  } snp_act_t;

endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store
  import mei_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAGW  = 4,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ca_idx,
  output logic [TAGW-1:0] ca_tag,
  output line_st_e        ca_st,
  input  logic [IDXW-1:0] sn_idx,
  output logic [TAGW-1:0] sn_tag,
  output line_st_e        sn_st,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_tag_en,
  input  logic [TAGW-1:0] wr_tag,
  input  line_st_e        wr_st
);

  line_st_e        st_q  [LINES];
  logic [TAGW-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
      end else if (wr_en && wr_idx == IDXW'(i)) begin
        st_q[i] <= wr_st;
        if (wr_tag_en) tag_q[i] <= wr_tag;
      end
    end
  end

  assign ca_tag = tag_q[ca_idx];
  assign ca_st  = st_q[ca_idx];
  assign sn_tag = tag_q[sn_idx];
  assign sn_st  = st_q[sn_idx];

  // R3
  fill_lands_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_tag_en |-> wr_st == LS_EXC);

endmodule

// File: rtl/mei_snoop_eval.sv
module mei_snoop_eval
  import mei_pkg::*;
(
  input  logic     snp_valid,
  input  logic     snp_coh,
  input  logic     snp_inh,
  input  logic     tag_match,
  input  line_st_e line_st,
  output snp_act_t act
);

  always_comb begin
    act.hit   = snp_valid && snp_coh && tag_match && (line_st != LS_INV);
    act.push  = act.hit && (line_st == LS_MOD);
    act.inval = act.hit && (line_st == LS_EXC) && !snp_inh;
  end

endmodule

// File: rtl/mei_line_ctrl.sv
module mei_line_ctrl
  import mei_pkg::*;
#(
  parameter int LINES = 16,
  parameter int LAW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_valid,
  output logic           cpu_ready,
  input  logic           cpu_write,
  input  logic           cpu_coh,
  input  logic [LAW-1:0] cpu_addr,
  input  logic           snp_valid,
  input  logic           snp_coh,
  input  logic           snp_inh,
  input  logic [LAW-1:0] snp_addr,
  output logic           snp_hit,
  output logic           snp_retry,
  output logic           bus_req_valid,
  input  logic           bus_req_ready,
  output logic [1:0]     bus_op,
  output logic [LAW-1:0] bus_addr
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = LAW - IDXW;

  ctl_st_e         cs_q, cs_d;
  logic [LAW-1:0]  req_addr_q;
  logic            req_coh_q;
  logic [LAW-1:0]  bus_addr_q;
  bus_op_e         op_q;
  logic [IDXW-1:0] push_idx_q;
  logic            push_keep_q;

  logic [IDXW-1:0] c_idx, s_idx;
  logic [TAGW-1:0] c_tag, s_tag;
  logic [TAGW-1:0] c_tag_st, s_tag_st;
  line_st_e        c_st, s_st;
  logic            c_hit, snp_live;
  snp_act_t        s_act;

  logic            wr_en, wr_tag_en;
  logic [IDXW-1:0] wr_idx;
  logic [TAGW-1:0] wr_tag;
  line_st_e        wr_st;

  assign c_idx    = cpu_addr[IDXW-1:0];
  assign c_tag    = cpu_addr[LAW-1:IDXW];
  assign s_idx    = snp_addr[IDXW-1:0];
  assign s_tag    = snp_addr[LAW-1:IDXW];
  assign snp_live = snp_valid && snp_coh;
  assign c_hit    = (c_st != LS_INV) && (c_tag_st == c_tag);

  mei_tag_store #(.LINES(LINES), .TAGW(TAGW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ca_idx   (c_idx),
    .ca_tag   (c_tag_st),
    .ca_st    (c_st),
    .sn_idx   (s_idx),
    .sn_tag   (s_tag_st),
    .sn_st    (s_st),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag_en(wr_tag_en),
    .wr_tag   (wr_tag),
    .wr_st    (wr_st)
  );

  mei_snoop_eval u_seval (
    .snp_valid(snp_valid),
    .snp_coh  (snp_coh),
    .snp_inh  (snp_inh),
    .tag_match(s_tag_st == s_tag),
    .line_st  (s_st),
    .act      (s_act)
  );

  // next state, array writes and responses
  always_comb begin
    cs_d      = cs_q;
    wr_en     = 1'b0;
    wr_idx    = '0;
    wr_tag_en = 1'b0;
    wr_tag    = '0;
    wr_st     = LS_INV;
    cpu_ready = 1'b0;
    snp_hit   = 1'b0;
    snp_retry = 1'b0;
    unique case (cs_q)
      CS_IDLE: begin
        if (snp_live) begin
          snp_hit = s_act.hit;
          if (s_act.push) begin
            snp_retry = 1'b1;
            cs_d      = CS_PUSH;
          end else if (s_act.inval) begin
            wr_en  = 1'b1;
            wr_idx = s_idx;
            wr_st  = LS_INV;
          end
        end else if (cpu_valid) begin
          if (c_hit) begin
            cpu_ready = 1'b1;
            if (cpu_write) begin
              wr_en  = 1'b1;
              wr_idx = c_idx;
              wr_st  = LS_MOD;
            end
          end else begin
            cs_d = (c_st == LS_MOD) ? CS_VICT : CS_FILL;
          end
        end
      end
      CS_VICT: begin
        snp_retry = snp_live;
        if (bus_req_ready) begin
          wr_en  = 1'b1;
          wr_idx = req_addr_q[IDXW-1:0];
          wr_st  = LS_INV;
          cs_d   = CS_FILL;
        end
      end
      CS_FILL: begin
        snp_retry = snp_live;
        if (bus_req_ready) begin
          wr_en     = 1'b1;
          wr_idx    = req_addr_q[IDXW-1:0];
          wr_tag_en = 1'b1;
          wr_tag    = req_addr_q[LAW-1:IDXW];
          wr_st     = LS_EXC;
          cs_d      = CS_IDLE;
        end
      end
      CS_PUSH: begin
        snp_retry = snp_live;
        if (bus_req_ready) begin
          wr_en  = 1'b1;
          wr_idx = push_idx_q;
          wr_st  = push_keep_q ? LS_EXC : LS_INV;
          cs_d   = CS_IDLE;
        end
      end
      default: cs_d = CS_IDLE;
    endcase
  end

  // request registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= CS_IDLE;
      req_addr_q  <= '0;
      req_coh_q   <= 1'b0;
      bus_addr_q  <= '0;
      op_q        <= BOP_READ;
      push_idx_q  <= '0;
      push_keep_q <= 1'b0;
    end else begin
      cs_q <= cs_d;
      unique case (cs_q)
        CS_IDLE: begin
          if (snp_live) begin
            if (s_act.push) begin
              bus_addr_q  <= snp_addr;
              op_q        <= BOP_PUSH;
              push_idx_q  <= s_idx;
              push_keep_q <= snp_inh;
            end
          end else if (cpu_valid && !c_hit) begin
            req_addr_q <= cpu_addr;
            req_coh_q  <= cpu_coh;
            if (c_st == LS_MOD) begin
              bus_addr_q <= {c_tag_st, c_idx};
              op_q       <= BOP_WBACK;
            end else begin
              bus_addr_q <= cpu_addr;
              op_q       <= cpu_coh ? BOP_RWITM : BOP_READ;
            end
          end
        end
        CS_VICT: begin
          if (bus_req_ready) begin
            bus_addr_q <= req_addr_q;
            op_q       <= req_coh_q ? BOP_RWITM : BOP_READ;
          end
        end
        default: ;
      endcase
    end
  end

  assign bus_req_valid = (cs_q != CS_IDLE);
  assign bus_op        = op_q;
  assign bus_addr      = bus_addr_q;

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=>
      bus_req_valid && $stable(bus_op) && $stable(bus_addr));

  // R11
  victim_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready && bus_op == BOP_WBACK |=>
      bus_req_valid && (bus_op == BOP_READ || bus_op == BOP_RWITM));

  // R10
  busy_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && snp_valid && snp_coh |-> snp_retry);

  // R9
  no_coh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && snp_coh) |-> !snp_retry && !snp_hit);

  // R5
  push_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry && !bus_req_valid |=>
      bus_req_valid && bus_op == BOP_PUSH && bus_addr == $past(snp_addr));

  // R4
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> !bus_req_valid);

  // R13
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_coh |-> !cpu_ready);

endmodule

// File: tb/mei_line_ctrl_test.sv
module mei_line_ctrl_test;

  localparam int LINES = 16;
  localparam int LAW   = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam int TAGW  = LAW - IDXW;
  localparam logic [TAGW-1:0] TAG1 = 4'h3;
  localparam logic [TAGW-1:0] TAG2 = 4'hA;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cpu_valid = 1'b0, cpu_write = 1'b0, cpu_coh = 1'b0;
  logic [LAW-1:0] cpu_addr = '0;
  logic           snp_valid = 1'b0, snp_coh = 1'b0, snp_inh = 1'b0;
  logic [LAW-1:0] snp_addr = '0;
  logic           bus_req_ready = 1'b0;
  logic           cpu_ready, snp_hit, snp_retry, bus_req_valid;
  logic [1:0]     bus_op;
  logic [LAW-1:0] bus_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int              exp_st  [LINES];   // 0 invalid, 1 exclusive, 2 modified
  logic [TAGW-1:0] exp_tag [LINES];

  always #10 clk = ~clk;

  mei_line_ctrl #(.LINES(LINES), .LAW(LAW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_coh(cpu_coh), .cpu_addr(cpu_addr),
    .snp_valid(snp_valid), .snp_coh(snp_coh), .snp_inh(snp_inh),
    .snp_addr(snp_addr), .snp_hit(snp_hit), .snp_retry(snp_retry),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_op(bus_op), .bus_addr(bus_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [1:0] op, input logic [LAW-1:0] a,
                       input int stall, input string req);
    @(negedge clk); #2;
    check(bus_req_valid === 1'b1, req, "bus request", 32'(bus_req_valid), 1);
    check(bus_op === op, req, "bus op", 32'(bus_op), 32'(op));
    check(bus_addr === a, req, "bus address", 32'(bus_addr), 32'(a));
    if (snp_valid && snp_coh)
      check(snp_retry === 1'b1, "R10", "retry while busy", 32'(snp_retry), 1);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk); #2;
      check(bus_req_valid === 1'b1 && bus_op === op && bus_addr === a, "R12",
            "request held", 32'(bus_addr), 32'(a));
      if (snp_valid && snp_coh)
        check(snp_retry === 1'b1, "R10", "retry while busy", 32'(snp_retry), 1);
    end
    bus_req_ready = 1'b1;
    @(posedge clk); #1;
    bus_req_ready = 1'b0;
  endtask

  task automatic cpu_access(input logic [LAW-1:0] a, input logic wr,
                            input logic coh, input int stall);
    int idx = int'(a[IDXW-1:0]);
    logic [TAGW-1:0] tg = a[LAW-1:IDXW];
    bit hit = (exp_st[idx] != 0) && (exp_tag[idx] == tg);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_coh = coh; cpu_addr = a;
    #2;
    if (hit) begin
      // R14 same-cycle acceptance; R4 no bus request on a write hit
      check(cpu_ready === 1'b1, "R14", "hit accepted", 32'(cpu_ready), 1);
      check(bus_req_valid === 1'b0, "R4", "no bus on hit", 32'(bus_req_valid), 0);
      @(posedge clk);
      if (wr) exp_st[idx] = 2;
    end else begin
      check(cpu_ready === 1'b0, "R14", "miss not accepted", 32'(cpu_ready), 0);
      @(posedge clk);
      if (exp_st[idx] == 2)
        serve(2'd3, {exp_tag[idx], a[IDXW-1:0]}, stall, "R11");
      serve(coh ? 2'd1 : 2'd0, a, stall, "R2");
      exp_st[idx]  = 1;
      exp_tag[idx] = tg;
      @(negedge clk); #2;
      check(cpu_ready === 1'b1, "R3", "accepted after fill", 32'(cpu_ready), 1);
      @(posedge clk);
      if (wr) exp_st[idx] = 2;
    end
    @(negedge clk);
    cpu_valid = 1'b0; cpu_write = 1'b0;
  endtask

  task automatic snoop(input logic [LAW-1:0] a, input logic inh,
                       input logic coh, input int stall);
    int idx = int'(a[IDXW-1:0]);
    logic [TAGW-1:0] tg = a[LAW-1:IDXW];
    bit hit = coh && (exp_st[idx] != 0) && (exp_tag[idx] == tg);
    @(negedge clk);
    snp_valid = 1'b1; snp_coh = coh; snp_inh = inh; snp_addr = a;
    #2;
    if (!coh) begin
      check(snp_hit === 1'b0 && snp_retry === 1'b0, "R9", "ignored snoop",
            32'({snp_hit, snp_retry}), 0);
      @(posedge clk);
    end else if (hit && exp_st[idx] == 2) begin
      check(snp_hit === 1'b1 && snp_retry === 1'b1, inh ? "R7" : "R5",
            "dirty hit retried", 32'({snp_hit, snp_retry}), 3);
      @(posedge clk);
      serve(2'd2, a, stall, inh ? "R7" : "R5");
      exp_st[idx] = inh ? 1 : 0;
    end else if (hit) begin
      check(snp_hit === 1'b1 && snp_retry === 1'b0, inh ? "R8" : "R6",
            "clean hit response", 32'({snp_hit, snp_retry}), 2);
      @(posedge clk);
      if (!inh) exp_st[idx] = 0;
      @(negedge clk); #2;
      check(bus_req_valid === 1'b0, inh ? "R8" : "R6", "no bus after clean hit",
            32'(bus_req_valid), 0);
    end else begin
      check(snp_hit === 1'b0 && snp_retry === 1'b0, "R6", "snoop miss quiet",
            32'({snp_hit, snp_retry}), 0);
      @(posedge clk);
    end
    snp_valid = 1'b0; snp_coh = 1'b0; snp_inh = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin exp_st[i] = 0; exp_tag[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    // R1 outputs quiet during and after reset
    check(bus_req_valid === 1'b0 && snp_retry === 1'b0 && snp_hit === 1'b0 &&
          cpu_ready === 1'b0, "R1", "reset outputs",
          32'({bus_req_valid, snp_retry, snp_hit, cpu_ready}), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 every line invalid: snoops at tag 0 must miss
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      snp_valid = 1'b1; snp_coh = 1'b1; snp_inh = 1'b0; snp_addr = LAW'(i);
      #2;
      check(snp_hit === 1'b0 && snp_retry === 1'b0, "R1", "line invalid",
            32'({snp_hit, snp_retry}), 0);
    end
    @(negedge clk); snp_valid = 1'b0; snp_coh = 1'b0;

    // fills, coherent and non-coherent alternating (R2, R3)
    for (int i = 0; i < LINES; i++)
      cpu_access({TAG1, IDXW'(i)}, 1'b0, logic'(i % 2), i % 3);

    // inhibited snoop on clean lines, non-coherent snoop, then load hit (R8, R9, R14)
    for (int i = 0; i < LINES; i++) begin
      snoop({TAG1, IDXW'(i)}, 1'b1, 1'b1, 0);
      snoop({TAG1, IDXW'(i)}, 1'b0, 1'b0, 0);
      cpu_access({TAG1, IDXW'(i)}, 1'b0, 1'b1, 0);
    end

    // R13 coherent snoop in the same idle cycle as a load hit
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_coh = 1'b1; cpu_addr = {TAG1, 4'd0};
    snp_valid = 1'b1; snp_coh = 1'b1; snp_inh = 1'b0; snp_addr = {TAG2, 4'd1};
    #2;
    check(cpu_ready === 1'b0, "R13", "snoop takes the cycle", 32'(cpu_ready), 0);
    @(negedge clk); snp_valid = 1'b0; snp_coh = 1'b0; #2;
    check(cpu_ready === 1'b1, "R13", "access next cycle", 32'(cpu_ready), 1);
    @(negedge clk); cpu_valid = 1'b0;

    // store to exclusive, ignored snoop, then pushes of both kinds (R4, R5, R7, R9, R10)
    for (int i = 0; i < LINES; i++) begin
      cpu_access({TAG1, IDXW'(i)}, 1'b1, 1'b1, 0);
      snoop({TAG1, IDXW'(i)}, logic'(i % 2), 1'b0, 0);
      snoop({TAG1, IDXW'(i)}, logic'(i % 2), 1'b1, i % 4);
    end

    // dirty line then conflicting load: victim write-back before fill (R11)
    for (int i = 0; i < LINES; i++) begin
      cpu_access({TAG1, IDXW'(i)}, 1'b1, 1'b1, i % 2);
      cpu_access({TAG2, IDXW'(i)}, 1'b0, logic'((i / 2) % 2), (i + 1) % 3);
    end

    // cacheable snoop invalidates clean lines; repeat misses; reload shows invalid (R6)
    for (int i = 0; i < LINES; i++) begin
      snoop({TAG2, IDXW'(i)}, 1'b0, 1'b1, 0);
      snoop({TAG2, IDXW'(i)}, 1'b0, 1'b1, 0);
      cpu_access({TAG2, IDXW'(i)}, 1'b0, 1'b1, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule